// File: doc/BRIEF.md
# KCS BMC-Side Transfer Engine

This block is the management-controller end of a keyboard-controller-style IPMI channel. A host bus decoder (outside this block) hands it each byte the host writes, with a flag that tells a command-port write from a data-port write. From those bytes the engine runs the whole transfer handshake. It drives the two-bit state field of the status register, loads the output data register and pulses a strobe each time that register is loaded, which raises the output-full flag. It also collects the incoming request into a buffer.

When the last request byte arrives, the engine pulses a message-ready indication to local logic. Local logic reads the request through a read port. It then starts the response by giving a length and a start strobe. The engine fetches response bytes by address from local logic, one byte per host read-request. It also runs the abort sequence, which reads out the error code in two steps, and it handles illegal control codes. A local force-abort input puts the channel into the error state, the same as a reset.

Top module: `kcs_xfer_engine`

## Requirements
- R1: After reset, and in the cycle after force_abort_i, state_o is 3 (error) and odr_o is 0. A force-abort also pulses obf_set_o.
- R2: A command-port byte of 0x61 (write-start), 0x62 (write-end) or 0x60 (abort) sets state_o to 2 (write), loads odr_o with 0 and pulses obf_set_o.
- R3: After write-start, each data byte is kept at state 2 with a dummy 0 output, and is stored in order. req_len_o counts the stored bytes and req_rd_data_o returns byte k for req_rd_addr_i = k. Write-start clears the count.
- R4: Data bytes beyond DEPTH are dropped. The count stays at DEPTH and the stored bytes are not overwritten.
- R5: After write-end, the next data byte is stored as the last byte. state_o becomes 1 (read) and msg_ready_o pulses for exactly one cycle.
- R6: In the read phase, rsp_start_i with 1 <= rsp_len_i <= DEPTH loads odr_o with the response byte at address 0 and pulses obf_set_o. Any start strobe is rejected with a one-cycle rsp_err_o pulse, and odr_o left unchanged, in three cases: outside the read phase, with length 0, or with a length above DEPTH.
- R7: In the read phase, each data byte 0x68 (read-byte) loads the next response byte. Once all rsp_len_i bytes have been sent, the next 0x68 sets state_o to 0 (idle), outputs 0 and ends the transfer.
- R8: In the read phase, a data byte other than 0x68 sets state_o to 3 and outputs 0.
- R9: An abort sets the error code to 0x01 if it is 0. The first data byte afterwards gives state_o = 1 with odr_o = error code. The second gives state_o = 0 with odr_o = 0.
- R10: A command byte other than 0x60, 0x61 or 0x62 records error code 0x02 and sets state_o to 3 with odr_o = 0x02. A later abort reports 0x02 and does not replace it.
- R11: A data byte received in the idle or error phase gives state_o = 3, odr_o = 0 and an obf_set_o pulse.
- R12: Write-start clears the error code, so an abort after it reports 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | One-cycle strobe: host wrote a byte (input buffer full) |
| host_is_cmd_i | input | 1 | 1 = byte went to the command port, 0 = data port |
| host_byte_i | input | 8 | Byte written by the host |
| force_abort_i | input | 1 | Local request to force the error state |
| state_o | output | 2 | Status state field: 0 idle, 1 read, 2 write, 3 error |
| odr_o | output | 8 | Output data register contents |
| obf_set_o | output | 1 | One-cycle pulse when odr_o is loaded (raises output-full) |
| msg_ready_o | output | 1 | One-cycle pulse: a request message is complete |
| req_len_o | output | $clog2(DEPTH)+1 | Number of stored request bytes |
| req_rd_addr_i | input | $clog2(DEPTH) | Request buffer read address |
| req_rd_data_o | output | 8 | Request byte at req_rd_addr_i |
| rsp_start_i | input | 1 | Start strobe for a response |
| rsp_len_i | input | $clog2(DEPTH)+1 | Response length in bytes |
| rsp_rd_addr_o | output | $clog2(DEPTH) | Address of the response byte wanted from local logic |
| rsp_rd_data_i | input | 8 | Response byte at rsp_rd_addr_o, same cycle |
| rsp_err_o | output | 1 | One-cycle pulse: start strobe rejected |

## Verification
The case that is hardest to reach from the ports is an abort that has to report an error recorded earlier rather than 0x01. The error code cannot be seen directly, and only an abort readout brings it out. The stimulus first sweeps every illegal command value, then issues an abort, and checks that the two-step readout gives 0x02. It then issues write-start and another abort and checks that the code has been cleared back to 0x01. Request-buffer overflow is reached by sweeping message lengths past a small buffer depth, and each sweep pairs the message with a response whose length changes from run to run.

// File: rtl/kcs_xfer_pkg.sv
// Shared encodings for the KCS transfer engine: phases, state field values,
// control codes and error codes. Assumes 8-bit host bytes.
package kcs_xfer_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_WRITE, PH_WEND, PH_READ, PH_ABT1, PH_ABT2, PH_ERROR
    } phase_t;

    localparam logic [1:0] ST_IDLE  = 2'd0;
    localparam logic [1:0] ST_READ  = 2'd1;
    localparam logic [1:0] ST_WRITE = 2'd2;
    localparam logic [1:0] ST_ERROR = 2'd3;

    localparam logic [7:0] CC_ABORT  = 8'h60;
    localparam logic [7:0] CC_WSTART = 8'h61;
    localparam logic [7:0] CC_WEND   = 8'h62;
    localparam logic [7:0] CC_RDBYTE = 8'h68;

    localparam logic [7:0] EC_NONE    = 8'h00;
    localparam logic [7:0] EC_ABORTED = 8'h01;
    localparam logic [7:0] EC_ILLEGAL = 8'h02;
endpackage

// File: rtl/kcs_req_store.sv
// Request buffer: appends bytes at a running count and saturates at DEPTH,
// so bytes past capacity are dropped without wrapping. Has an asynchronous
// read port. Assumes clr and push are never needed in the same cycle
// (clr wins if they are).
module kcs_req_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    output logic [LW-1:0] count,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];
    logic       room;

    assign room    = (count < LW'(DEPTH));
    assign rd_data = mem[rd_addr];

    // Count of stored bytes: cleared on clr, bumped on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     count <= '0;
        else if (push && room) count <= count + 1'b1;
    end

    // Storage write at the current count while there is room.
    always_ff @(posedge clk) begin
        if (push && room && !clr) mem[count[AW-1:0]] <= din;
    end

    // R4: a push into a full buffer leaves the count untouched.
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count == LW'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/kcs_rsp_cursor.sv
// Response cursor: holds the response length and the index of the next
// byte to send. load starts a response with byte 0 already sent.
module kcs_rsp_cursor #(
    parameter int DEPTH = 1024,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [LW-1:0] load_len,
    input  logic          step,
    output logic [LW-1:0] idx,
    output logic          done
);
    logic [LW-1:0] len_q;

    assign done = (idx == len_q);

    // Index and length registers for the response in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx   <= '0;
            len_q <= '0;
        end else if (load) begin
            idx   <= LW'(1);
            len_q <= load_len;
        end else if (step) begin
            idx   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/kcs_phase_ctl.sv
// Phase controller: decodes command and data bytes by phase, drives the
// state field and the output data register, and keeps the error code.
// Priority order: force-abort, then host byte, then response start.
module kcs_phase_ctl
    import kcs_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_is_cmd,
    input  logic [7:0] host_byte,
    input  logic       force_abort,
    input  logic       rsp_start,
    input  logic       rsp_len_ok,
    input  logic [7:0] rsp_byte,
    input  logic       rsp_done,
    output logic [1:0] state,
    output logic [7:0] odr,
    output logic       obf_set,
    output logic       msg_ready,
    output logic       rsp_err,
    output logic       req_clr,
    output logic       req_push,
    output logic       cur_clr,
    output logic       cur_load,
    output logic       cur_step
);
    phase_t     ph_q, ph_n;
    logic [1:0] st_n;
    logic [7:0] odr_n, err_q, err_n;
    logic       obf_n, rdy_n, rej_n;

    // Next-state decode for phase, state field, output byte and error code.
    always_comb begin
        ph_n = ph_q; st_n = state; odr_n = odr; err_n = err_q;
        obf_n = 1'b0; rdy_n = 1'b0; rej_n = 1'b0;
        req_clr = 1'b0; req_push = 1'b0;
        cur_clr = 1'b0; cur_load = 1'b0; cur_step = 1'b0;
        if (force_abort) begin
            st_n = ST_ERROR; odr_n = 8'h00; obf_n = 1'b1; ph_n = PH_ERROR;
            rej_n = rsp_start;
        end else if (host_wr && host_is_cmd) begin
            st_n = ST_WRITE; odr_n = 8'h00; obf_n = 1'b1; rej_n = rsp_start;
            case (host_byte)
                CC_WSTART: begin
                    req_clr = 1'b1; err_n = EC_NONE; ph_n = PH_WRITE;
                end
                CC_WEND:   ph_n = PH_WEND;
                CC_ABORT: begin
                    if (err_q == EC_NONE) err_n = EC_ABORTED;
                    ph_n = PH_ABT1;
                end
                default: begin
                    err_n = EC_ILLEGAL; st_n = ST_ERROR;
                    odr_n = EC_ILLEGAL; ph_n = PH_ERROR;
                end
            endcase
        end else if (host_wr) begin
            rej_n = rsp_start;
            case (ph_q)
                PH_WRITE: begin
                    st_n = ST_WRITE; odr_n = 8'h00; obf_n = 1'b1; req_push = 1'b1;
                end
                PH_WEND: begin
                    req_push = 1'b1; st_n = ST_READ; ph_n = PH_READ;
                    rdy_n = 1'b1; cur_clr = 1'b1;
                end
                PH_READ: begin
                    obf_n = 1'b1;
                    if (host_byte != CC_RDBYTE) begin
                        st_n = ST_ERROR; odr_n = 8'h00; ph_n = PH_ERROR;
                    end else if (rsp_done) begin
                        st_n = ST_IDLE; odr_n = 8'h00; ph_n = PH_IDLE;
                    end else begin
                        odr_n = rsp_byte; cur_step = 1'b1;
                    end
                end
                PH_ABT1: begin
                    st_n = ST_READ; odr_n = err_q; obf_n = 1'b1; ph_n = PH_ABT2;
                end
                PH_ABT2: begin
                    st_n = ST_IDLE; odr_n = 8'h00; obf_n = 1'b1; ph_n = PH_IDLE;
                end
                default: begin
                    st_n = ST_ERROR; odr_n = 8'h00; obf_n = 1'b1;
                end
            endcase
        end else if (rsp_start) begin
            if (ph_q == PH_READ && rsp_len_ok) begin
                odr_n = rsp_byte; obf_n = 1'b1; cur_load = 1'b1;
            end else begin
                rej_n = 1'b1;
            end
        end
    end

    // Registered outputs; reset lands in the error phase and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_ERROR; state <= ST_ERROR; odr <= 8'h00; err_q <= EC_NONE;
            obf_set <= 1'b0; msg_ready <= 1'b0; rsp_err <= 1'b0;
        end else begin
            ph_q <= ph_n; state <= st_n; odr <= odr_n; err_q <= err_n;
            obf_set <= obf_n; msg_ready <= rdy_n; rsp_err <= rej_n;
        end
    end

    // R1: force-abort lands in the error state with a zero output.
    p_force_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        force_abort |=> (state == ST_ERROR && odr == 8'h00));
    // R2: legal command bytes give write state and a dummy zero.
    p_cmd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_abort && host_wr && host_is_cmd &&
         (host_byte == CC_ABORT || host_byte == CC_WSTART || host_byte == CC_WEND))
        |=> (state == ST_WRITE && odr == 8'h00 && obf_set));
    // R5: message-ready lasts a single cycle.
    p_msg_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |=> !msg_ready);
    // R6: a start strobe outside the read phase is refused.
    p_rsp_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_start && !host_wr && !force_abort && ph_q != PH_READ) |=> rsp_err);
    // R8: a bad byte while sending the response gives error state.
    p_bad_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_abort && host_wr && !host_is_cmd && ph_q == PH_READ &&
         host_byte != CC_RDBYTE) |=> (state == ST_ERROR && odr == 8'h00));
endmodule

// File: rtl/kcs_xfer_engine.sv
// KCS BMC-side transfer engine top: ties the phase controller to the
// request buffer and the response cursor. Response bytes are fetched
// combinationally from local logic by address.
module kcs_xfer_engine #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_i,
    input  logic          host_is_cmd_i,
    input  logic [7:0]    host_byte_i,
    input  logic          force_abort_i,
    output logic [1:0]    state_o,
    output logic [7:0]    odr_o,
    output logic          obf_set_o,
    output logic          msg_ready_o,
    output logic [LW-1:0] req_len_o,
    input  logic [AW-1:0] req_rd_addr_i,
    output logic [7:0]    req_rd_data_o,
    input  logic          rsp_start_i,
    input  logic [LW-1:0] rsp_len_i,
    output logic [AW-1:0] rsp_rd_addr_o,
    input  logic [7:0]    rsp_rd_data_i,
    output logic          rsp_err_o
);
    logic          req_clr, req_push, cur_clr, cur_load, cur_step, rsp_done;
    logic [LW-1:0] cur_idx;
    logic          len_ok;

    assign len_ok        = (rsp_len_i != '0) && (rsp_len_i <= LW'(DEPTH));
    assign rsp_rd_addr_o = (rsp_start_i && !host_wr_i) ? '0 : cur_idx[AW-1:0];

    kcs_phase_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr_i), .host_is_cmd(host_is_cmd_i), .host_byte(host_byte_i),
        .force_abort(force_abort_i), .rsp_start(rsp_start_i), .rsp_len_ok(len_ok),
        .rsp_byte(rsp_rd_data_i), .rsp_done(rsp_done),
        .state(state_o), .odr(odr_o), .obf_set(obf_set_o), .msg_ready(msg_ready_o),
        .rsp_err(rsp_err_o), .req_clr(req_clr), .req_push(req_push),
        .cur_clr(cur_clr), .cur_load(cur_load), .cur_step(cur_step)
    );

    kcs_req_store #(.DEPTH(DEPTH)) u_req (
        .clk(clk), .rst_n(rst_n), .clr(req_clr), .push(req_push), .din(host_byte_i),
        .count(req_len_o), .rd_addr(req_rd_addr_i), .rd_data(req_rd_data_o)
    );

    kcs_rsp_cursor #(.DEPTH(DEPTH)) u_cur (
        .clk(clk), .rst_n(rst_n), .clr(cur_clr), .load(cur_load),
        .load_len(rsp_len_i), .step(cur_step), .idx(cur_idx), .done(rsp_done)
    );
endmodule

// File: tb/tb_kcs_xfer_engine.sv
module tb_kcs_xfer_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          host_wr = 1'b0, host_is_cmd = 1'b0, force_abort = 1'b0;
    logic [7:0]    host_byte = 8'h00;
    logic [1:0]    state;
    logic [7:0]    odr, req_rd_data, rsp_rd_data;
    logic          obf_set, msg_ready, rsp_err, rsp_start = 1'b0;
    logic [LW-1:0] req_len, rsp_len = '0;
    logic [AW-1:0] req_rd_addr = '0, rsp_rd_addr;
    int            total = 0, bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Local response source: byte at address a is a*37+90.
    assign rsp_rd_data = 8'(32'(rsp_rd_addr) * 37 + 90);

    kcs_xfer_engine #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr), .host_is_cmd_i(host_is_cmd),
        .host_byte_i(host_byte), .force_abort_i(force_abort), .state_o(state),
        .odr_o(odr), .obf_set_o(obf_set), .msg_ready_o(msg_ready), .req_len_o(req_len),
        .req_rd_addr_i(req_rd_addr), .req_rd_data_o(req_rd_data), .rsp_start_i(rsp_start),
        .rsp_len_i(rsp_len), .rsp_rd_addr_o(rsp_rd_addr), .rsp_rd_data_i(rsp_rd_data),
        .rsp_err_o(rsp_err)
    );

    function automatic logic [7:0] rsp_val(input int a);
        return 8'(a * 37 + 90);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic hb(input bit cmd, input logic [7:0] b);
        host_is_cmd = cmd; host_byte = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic start_rsp(input int len);
        rsp_len = LW'(len); rsp_start = 1'b1;
        @(negedge clk);
        rsp_start = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 reset state", state, 3);
        chk("R1 reset odr", odr, 0);

        hb(1'b0, 8'h33);
        chk("R11 error-phase data state", state, 3);
        chk("R11 error-phase data odr", odr, 0);
        chk("R11 error-phase data obf", obf_set, 1);
        start_rsp(2);
        chk("R6 start outside read rejected", rsp_err, 1);
        chk("R6 reject keeps odr", odr, 0);

        // Message and response sweep over lengths across the buffer depth.
        for (int n = 1; n <= 10; n++) begin
            int kept, m;
            kept = (n < DEPTH) ? n : DEPTH;
            m = (n % DEPTH) + 1;
            hb(1'b1, 8'h61);
            chk("R2 write-start state", state, 2);
            chk("R2 write-start odr", odr, 0);
            chk("R2 write-start obf", obf_set, 1);
            for (int i = 0; i < n - 1; i++) begin
                hb(1'b0, 8'(i * 13 + n));
                chk("R3 write data state", state, 2);
                chk("R3 write data odr", odr, 0);
            end
            hb(1'b1, 8'h62);
            chk("R2 write-end state", state, 2);
            hb(1'b0, 8'((n - 1) * 13 + n));
            chk("R5 last byte state", state, 1);
            chk("R5 msg ready", msg_ready, 1);
            chk("R4 stored length", req_len, kept);
            for (int i = 0; i < kept; i++) begin
                req_rd_addr = AW'(i);
                #1;
                chk("R3 stored byte", req_rd_data, 8'(i * 13 + n));
            end
            tick();
            chk("R5 msg ready single cycle", msg_ready, 0);
            if (n == 3) begin
                start_rsp(0);
                chk("R6 zero length rejected", rsp_err, 1);
                start_rsp(DEPTH + 1);
                chk("R6 long length rejected", rsp_err, 1);
                chk("R6 rejected keeps state", state, 1);
            end
            start_rsp(m);
            chk("R6 first response byte", odr, rsp_val(0));
            chk("R6 first byte obf", obf_set, 1);
            chk("R6 accepted no error", rsp_err, 0);
            for (int k = 1; k < m; k++) begin
                hb(1'b0, 8'h68);
                chk("R7 next response byte", odr, rsp_val(k));
                chk("R7 read state", state, 1);
            end
            hb(1'b0, 8'h68);
            chk("R7 end state idle", state, 0);
            chk("R7 end odr zero", odr, 0);
            hb(1'b0, 8'h11);
            chk("R11 idle-phase data state", state, 3);
            chk("R11 idle-phase data odr", odr, 0);
        end

        // Bad byte while sending a response.
        hb(1'b1, 8'h61); hb(1'b0, 8'hA1); hb(1'b1, 8'h62); hb(1'b0, 8'hA2);
        start_rsp(3);
        hb(1'b0, 8'h55);
        chk("R8 bad read byte state", state, 3);
        chk("R8 bad read byte odr", odr, 0);

        // Abort in the middle of a write with no earlier error.
        hb(1'b1, 8'h61); hb(1'b0, 8'h01);
        hb(1'b1, 8'h60);
        chk("R2 abort state", state, 2);
        hb(1'b0, 8'h00);
        chk("R9 abort step1 state", state, 1);
        chk("R9 abort step1 code", odr, 1);
        hb(1'b0, 8'h00);
        chk("R9 abort step2 state", state, 0);
        chk("R9 abort step2 odr", odr, 0);

        // Sweep of every illegal control code.
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h60 || c == 8'h61 || c == 8'h62) continue;
            hb(1'b1, 8'(c));
            chk("R10 illegal code state", state, 3);
            chk("R10 illegal code odr", odr, 2);
        end
        hb(1'b1, 8'h60); hb(1'b0, 8'h00);
        chk("R10 abort keeps illegal code", odr, 2);
        chk("R10 abort step1 state", state, 1);
        hb(1'b0, 8'h00);
        chk("R10 abort step2 state", state, 0);

        // Write-start clears the error code.
        hb(1'b1, 8'h61); hb(1'b1, 8'h60); hb(1'b0, 8'h00);
        chk("R12 cleared code after write-start", odr, 1);
        hb(1'b0, 8'h00);

        // Force-abort during a write.
        hb(1'b1, 8'h61); hb(1'b0, 8'h42);
        force_abort = 1'b1; tick(); force_abort = 1'b0;
        chk("R1 force state", state, 3);
        chk("R1 force odr", odr, 0);
        chk("R1 force obf", obf_set, 1);
        hb(1'b0, 8'h43);
        chk("R11 data after force", state, 3);
        chk("R11 data after force req len", req_len, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule